// File: doc/BRIEF.md
# Error-Correcting Two-Beat Memory with Separate Read and Write Ports

This block is a cycle-level model of a synchronous memory with one write port and one read port, both usable in the same cycle. Each port moves data as a pair of beats on a bus `DW` bits wide. The storage word is `2*DW` bits wide, so one address picks a two-beat pair and the address is one bit narrower than a beat-level address would be. A write gathers its two beats and any byte masks into one word. It adds extended-Hamming check bits and stores the result in a single array update. A read fetches one stored word, repairs any single flipped bit and returns the word as two beats, low half first.

Each word carries a flag that says whether its check bits can be trusted. A write that enables every byte sets the flag. A write that enables only some bytes clears it. From then on, reads of that word return the stored bits unchanged. A test port can flip any one stored bit so that error handling can be exercised. Pad timing is outside this model. The nominal two-and-a-half-cycle read delay appears here as whole clock edges.

Top module: `ecc_b2_sram`

## Requirements
- R1: A write command is accepted with its address and low beat in one cycle. The high beat follows in the next cycle, and both are stored as one word: low beat in bits DW-1:0, high beat above. A later read returns the low half first, then the high half.
- R2: In the cycle after an accepted write, `wr_cmd` is ignored and the inputs are that burst's second beat. In the cycle after an accepted read, `rd_cmd` is ignored.
- R3: If a read is accepted at clock edge c, its low beat is on `rd_data` with `rd_valid` high from edge c+2 until edge c+3. Its high beat follows for one more cycle. In every other cycle `rd_valid` is low.
- R4: Bit j of `wr_be` enables byte j (bits 8j+7:8j) of the beat on that cycle. Bytes that are not enabled keep their previous value, which is taken after correction if the word is protected.
- R5: A write with all 2*DW/8 byte enables set marks the word protected. A write with some but not all enables set marks it unprotected. A write with no enables set changes neither the data nor the flag.
- R6: A protected word with one flipped bit anywhere in its codeword reads back as the data that was written, and `rd_corrected` is high on both beats.
- R7: An unprotected word reads back as its raw stored data bits, including any flipped data bit, and `rd_corrected` stays low.
- R8: A read accepted in the same cycle as a write command to the same address, or in any later cycle, returns that write's data.
- R9: When `inj_en` is high at an edge, stored codeword bit `inj_bit` of word `inj_addr` is inverted. Bits 0 to 2*DW-1 are data, the check bits come next, and the top bit (index CW-1) is overall parity. An index of CW or more has no effect. A write stored to the same word at the same edge takes precedence.
- R10: While reset is held and directly after it, `rd_valid` and `rd_corrected` are low, and no burst is in progress, so a write command in the first cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Start of a write burst |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write beat (low beat, then high beat) |
| wr_be | input | DW/8 | Byte enables of the current write beat |
| rd_cmd | input | 1 | Start of a read burst |
| rd_addr | input | AW | Word address of the read |
| rd_data | output | DW | Read beat |
| rd_valid | output | 1 | rd_data holds a read beat |
| rd_corrected | output | 1 | Current read word had one bit repaired |
| inj_en | input | 1 | Invert one stored bit at this edge |
| inj_addr | input | AW | Word to corrupt |
| inj_bit | input | clog2(CW) | Codeword bit index to invert |

## Verification
Two collisions matter most. A write can commit a word on the same edge that a read fetches the same word. Bit injection can also hit a word on the same edge that a write stores it. Directed bursts issue a read and a write to one address in the same cycle, and inject into a word during its own write's second beat. A random phase mixes overlapping reads, writes, partial masks and injections. Each beat is compared with a bench model that applies the edge's store before the fetch and discards injections that collide with a store.

// File: rtl/ecc_b2_sram.sv
module ecc_b2_sram #(
  parameter int DW = 16,
  parameter int AW = 4,
  localparam int BW = DW / 8,
  localparam int WW = 2 * DW,
  localparam int P  = $clog2(WW + $clog2(WW) + 2),
  localparam int CW = WW + P + 1,
  localparam int IW = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] wr_be,
  input  logic          rd_cmd,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_corrected,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [IW-1:0] inj_bit
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [P-1:0] chk_of(input logic [WW-1:0] d);
    logic [P-1:0] c;
    int pos;
    c = '0;
    pos = 2;
    for (int i = 0; i < WW; i++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      if (d[i]) c ^= pos[P-1:0];
    end
    return c;
  endfunction

  function automatic logic [CW-1:0] encode(input logic [WW-1:0] d);
    logic [P-1:0] c;
    c = chk_of(d);
    return {^{c, d}, c, d};
  endfunction

  function automatic logic [WW-1:0] repair(input logic [CW-1:0] cw, input logic prot);
    logic [WW-1:0] d;
    logic [P-1:0] syn;
    int pos;
    d = cw[WW-1:0];
    syn = cw[WW +: P] ^ chk_of(d);
    pos = 2;
    if (prot && ^cw) begin
      for (int i = 0; i < WW; i++) begin
        pos++;
        while ((pos & (pos - 1)) == 0) pos++;
        if (pos == int'(syn)) d[i] = ~d[i];
      end
    end
    return d;
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;

  logic          wr_ph;
  logic [AW-1:0] wr_a;
  logic [DW-1:0] wr_d0;
  logic [BW-1:0] wr_b0;
  logic          wr_accept, wr_store, wr_full, wr_none;
  logic [2*BW-1:0] new_be;
  logic [WW-1:0] new_raw, old_data, merged;
  logic [CW-1:0] commit_cw;
  logic          inj_ok;

  assign wr_accept = rst_n & wr_cmd & ~wr_ph;
  assign new_be    = {wr_be, wr_b0};
  assign new_raw   = {wr_data, wr_d0};
  assign wr_full   = &new_be;
  assign wr_none   = ~|new_be;
  assign wr_store  = wr_ph & ~wr_none;
  assign old_data  = repair(mem[wr_a], vld[wr_a]);
  assign commit_cw = encode(merged);

  for (genvar b = 0; b < 2 * BW; b++) begin : g_merge
    assign merged[8*b +: 8] = new_be[b] ? new_raw[8*b +: 8] : old_data[8*b +: 8];
  end

  assign inj_ok = inj_en && (int'(inj_bit) < CW) && !(wr_store && inj_addr == wr_a);

  always_ff @(posedge clk) begin
    if (wr_store) mem[wr_a] <= commit_cw;
    if (inj_ok) mem[inj_addr] <= mem[inj_addr] ^ (CW'(1) << inj_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ph <= 1'b0;
      vld   <= '0;
    end else begin
      wr_ph <= wr_accept;
      if (wr_store) vld[wr_a] <= wr_full;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_accept) begin
      wr_a  <= wr_addr;
      wr_d0 <= wr_data;
      wr_b0 <= wr_be;
    end
  end

  logic          s1_v, s2_v, s2_vf, o_corr, rd_accept, fetch_hit;
  logic [AW-1:0] s1_a;
  logic [CW-1:0] s2_cw;
  logic [WW-1:0] o_word;
  logic [1:0]    o_st;

  assign rd_accept = rst_n & rd_cmd & ~s1_v;
  assign fetch_hit = wr_store && (wr_a == s1_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      o_st   <= 2'd0;
      o_corr <= 1'b0;
    end else begin
      s1_v <= rd_accept;
      s2_v <= s1_v;
      if (s2_v) begin
        o_st   <= 2'd1;
        o_corr <= s2_vf & ^s2_cw;
      end else begin
        o_st <= (o_st == 2'd1) ? 2'd2 : 2'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_accept) s1_a <= rd_addr;
    if (s1_v) begin
      s2_cw <= fetch_hit ? commit_cw : mem[s1_a];
      s2_vf <= fetch_hit ? wr_full : vld[s1_a];
    end
    if (s2_v) o_word <= repair(s2_cw, s2_vf);
  end

  assign rd_valid     = (o_st != 2'd0);
  assign rd_data      = (o_st == 2'd2) ? o_word[WW-1:DW] : o_word[DW-1:0];
  assign rd_corrected = o_corr & rd_valid;

  a_r1_commit_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph |-> $past(wr_accept));
  a_r2_one_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ph |=> !wr_ph);
  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_accept, 3) |-> (rd_valid && o_st == 2'd1));
  a_r3_high_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (o_st == 2'd1) |=> (o_st == 2'd2));
  a_r5_full_protects: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_store && wr_full) |-> vld[$past(wr_a)]);
  a_r5_partial_unprotects: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_store && !wr_full) |-> !vld[$past(wr_a)]);
  a_r7_no_flag_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !s2_vf) |=> !rd_corrected);
endmodule

// File: tb/sim_ecc_b2_sram.sv
`timescale 1ns/1ps
module sim_ecc_b2_sram;
  localparam int DW = 16, AW = 4, D = 16, CWB = 39;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic wcmd = 0, rcmd = 0, inj = 0;
  logic [AW-1:0] waddr = 0, raddr = 0, iaddr = 0;
  logic [DW-1:0] wdat = 0;
  logic [1:0] wbe = 0;
  logic [5:0] ibit = 0;
  logic [DW-1:0] rd_data;
  logic rd_valid, rd_corrected;

  ecc_b2_sram #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wcmd), .wr_addr(waddr), .wr_data(wdat),
    .wr_be(wbe), .rd_cmd(rcmd), .rd_addr(raddr), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_corrected(rd_corrected), .inj_en(inj),
    .inj_addr(iaddr), .inj_bit(ibit));

  int checks = 0, errs = 0, k = 0;
  logic d_wcmd = 0, d_rcmd = 0, d_inj = 0;
  logic [AW-1:0] d_waddr = 0, d_raddr = 0, d_iaddr = 0;
  logic [DW-1:0] d_wdat = 0;
  logic [1:0] d_wbe = 0;
  logic [5:0] d_ibit = 0;

  logic [31:0] mdat [D];
  bit mval [D];
  int mflip [D];
  bit wph = 0, rph = 0;
  logic [AW-1:0] wa, ra;
  logic [DW-1:0] wd0;
  logic [1:0] wbe0;
  bit xv [8];
  logic [DW-1:0] xd [8];
  bit xc [8];
  string xt [8];
  string cur_tag = "";

  task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, k);
    end
  endtask

  function automatic logic [31:0] vis(input int a);
    if (mval[a] || mflip[a] < 0 || mflip[a] >= 32) return mdat[a];
    return mdat[a] ^ (32'h1 << mflip[a]);
  endfunction

  task automatic cyc();
    int e;
    bit stored;
    logic [3:0] be;
    logic [31:0] nd, v;
    @(negedge clk);
    e = (k + 7) % 8;
    if (xv[e]) begin
      chk(rd_valid === 1'b1 && rd_data === xd[e] && rd_corrected === xc[e], xt[e],
          {rd_valid, rd_corrected, rd_data}, {1'b1, xc[e], xd[e]});
      xv[e] = 0;
    end else begin
      chk(rd_valid === 1'b0 && rd_corrected === 1'b0, "R3", {rd_valid, rd_corrected, rd_data}, 18'h0);
    end
    wcmd = d_wcmd; waddr = d_waddr; wdat = d_wdat; wbe = d_wbe;
    rcmd = d_rcmd; raddr = d_raddr; inj = d_inj; iaddr = d_iaddr; ibit = d_ibit;
    stored = 0;
    if (wph) begin
      be = {d_wbe, wbe0};
      nd = {d_wdat, wd0};
      if (be != 0) begin
        v = vis(wa);
        for (int b = 0; b < 4; b++) if (be[b]) v[8*b +: 8] = nd[8*b +: 8];
        mdat[wa] = v; mval[wa] = (be == 4'hF); mflip[wa] = -1;
        stored = 1;
      end
    end
    if (rph) begin
      v = vis(ra);
      xv[(k+1)%8] = 1; xd[(k+1)%8] = v[15:0];
      xv[(k+2)%8] = 1; xd[(k+2)%8] = v[31:16];
      xc[(k+1)%8] = mval[ra] && mflip[ra] >= 0;
      xc[(k+2)%8] = xc[(k+1)%8];
      xt[(k+1)%8] = cur_tag != "" ? cur_tag : (!mval[ra] ? "R7" : (mflip[ra] >= 0 ? "R6" : "R1"));
      xt[(k+2)%8] = xt[(k+1)%8];
    end
    if (d_inj && d_ibit < CWB && !(stored && wa == d_iaddr)) mflip[d_iaddr] = d_ibit;
    if (wph) wph = 0;
    else if (d_wcmd) begin wph = 1; wa = d_waddr; wd0 = d_wdat; wbe0 = d_wbe; end
    rph = d_rcmd && !rph;
    if (rph) ra = d_raddr;
    k++;
  endtask

  task automatic idle(input int n);
    d_wcmd = 0; d_rcmd = 0; d_inj = 0;
    repeat (n) cyc();
  endtask

  task automatic burst(input bit dw, input int a, input logic [31:0] w, input logic [3:0] b,
                       input bit dr, input int r);
    d_wcmd = dw; d_waddr = a[AW-1:0]; d_wdat = w[15:0]; d_wbe = b[1:0];
    d_rcmd = dr; d_raddr = r[AW-1:0];
    cyc();
    d_wcmd = 0; d_wdat = w[31:16]; d_wbe = b[3:2]; d_rcmd = 0;
    cyc();
  endtask

  task automatic inject(input int a, input int bitn);
    d_inj = 1; d_iaddr = a[AW-1:0]; d_ibit = bitn[5:0];
    cyc();
    d_inj = 0;
  endtask

  task automatic rd(input int a, input string tag);
    cur_tag = tag;
    burst(0, 0, 0, 0, 1, a);
    idle(3);
    cur_tag = "";
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < D; i++) begin mdat[i] = 0; mval[i] = 0; mflip[i] = -1; end
    for (int i = 0; i < 8; i++) xv[i] = 0;
    repeat (3) @(negedge clk);
    chk(rd_valid === 0 && rd_corrected === 0, "R10", {rd_valid, rd_corrected, rd_data}, 18'h0);
    rst_n = 1;
    cur_tag = "R10";
    burst(1, 0, 32'hA5A5_0F0F, 4'hF, 0, 0);
    cur_tag = "";
    for (int a = 1; a < D; a++) burst(1, a, 32'h1357_9BDF * a + a, 4'hF, 0, 0);
    idle(2);
    for (int a = 0; a < 4; a++) rd(a, "R1");
    burst(1, 3, 32'hDEAD_BEEF, 4'b0101, 0, 0);
    idle(1);
    rd(3, "R4");
    burst(1, 5, 32'hFFFF_FFFF, 4'h0, 0, 0);
    idle(1);
    rd(5, "R5");
    inject(6, 7);  rd(6, "R6");
    inject(7, 35); rd(7, "R6");
    inject(8, 38); rd(8, "R6");
    inject(3, 4);  rd(3, "R7");
    inject(9, 50); rd(9, "R9");
    d_wcmd = 1; d_waddr = 10; d_wdat = 16'h1111; d_wbe = 2'b11; cyc();
    d_wcmd = 0; d_wdat = 16'h2222; d_inj = 1; d_iaddr = 10; d_ibit = 2; cyc();
    d_inj = 0;
    rd(10, "R9");
    cur_tag = "R8";
    burst(1, 11, 32'hCAFE_F00D, 4'hF, 1, 11);
    idle(3);
    d_wcmd = 1; d_waddr = 11; d_wdat = 16'h4444; d_wbe = 2'b11; cyc();
    d_wcmd = 0; d_wdat = 16'h5555; d_rcmd = 1; d_raddr = 11; cyc();
    idle(4);
    cur_tag = "R2";
    d_wcmd = 1; d_waddr = 12; d_wdat = 16'h7777; d_wbe = 2'b11; cyc();
    d_wcmd = 1; d_waddr = 13; d_wdat = 16'h8888; cyc();
    d_rcmd = 1; d_raddr = 13; d_wcmd = 0; cyc();
    d_rcmd = 1; d_raddr = 12; cyc();
    idle(4);
    rd(13, "R2");
    rd(12, "R2");
    for (int n = 0; n < 3000; n++) begin
      d_wcmd = 0; d_rcmd = 0; d_inj = 0;
      d_wcmd = ($urandom % 2) == 0;
      d_waddr = $urandom % D;
      d_wdat = $urandom;
      case ($urandom % 7)
        0, 1: d_wbe = 2'b11;
        2: d_wbe = 2'b00;
        3: d_wbe = 2'b01;
        4: d_wbe = 2'b10;
        default: d_wbe = $urandom;
      endcase
      d_rcmd = ($urandom % 2) == 0;
      d_raddr = $urandom % D;
      if (($urandom % 8) == 0) begin
        d_iaddr = $urandom % D;
        d_ibit = $urandom % 40;
        d_inj = mflip[d_iaddr] < 0;
      end
      cyc();
    end
    idle(6);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule